// File: doc/BRIEF.md
# Dual-Half Interval Timer

This block is a general-purpose interval timer that software drives over a small register bus. Its 64-bit count store is split into two 32-bit halves, a lower and an upper. Each half has its own counter, its own period, its own 2-bit run mode and its own release bit, and each raises a separate interrupt. A half counts upward on every cycle where the timer clock enable is high. On the tick where its counter equals its period, it either wraps to zero (continuous) or holds and goes quiet (one-shot). The interrupt pulse appears in the following cycle.

The usual set-up is as follows. Software writes the periods and modes, then selects the split layout and releases the halves in the global register. It may clear or preset a counter at any time. A free-running cycle counter is a continuous half with a period of all ones. A single delayed event is a one-shot half that is rearmed by rewriting the mode register.

Top module: `split_timer_core`

## Requirements
- R1: Registers decode as follows: lower counter 0x10, upper counter 0x14, lower period 0x18, upper period 0x1C, mode register 0x20, global register 0x24. Reads are combinational. Any other address, 0x28 included, reads zero. The mode register reads back only its two mode fields, and the global register reads back only bits 3:0.
- R2: After reset, the global register is 0, both halves are held in reset, both counters read 0, both periods read 0xFFFFFFFF, the mode register reads 0 and both interrupts are low.
- R3: Global bit 0 releases the lower half and bit 1 releases the upper half (1 = running, 0 = held). While a half is held, its counter reads 0, counter writes to it are ignored and its interrupt stays low. Period and mode writes are still stored.
- R4: Global bits 3:2 select the layout. Only the value 1 (two separate halves) lets the counters advance. Any other value freezes both counters.
- R5: The lower mode field sits in mode-register bits 7:6 and the upper field in bits 23:22. The encodings are 0 = off, 1 = one-shot, 2 = continuous. The value 3 behaves like off, and an off half keeps its counter value.
- R6: A counter advances only on cycles where the timer clock enable is high.
- R7: In continuous mode, a tick with counter equal to period sets the counter to 0. The half's interrupt is then high for exactly the next cycle. Any other tick adds one.
- R8: In one-shot mode, the tick with counter equal to period pulses the interrupt once and the counter holds at the period. No further pulse occurs until the mode register or that counter is written again.
- R9: A write to a released half's counter loads the written value at the next edge and takes priority over a tick in the same cycle.
- R10: The two halves are independent. Each half's period, mode and release bit affect only its own counter and interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timer clock enable; one count per high cycle |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe, one write per high cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| irqLo | output | 1 | Lower-half interrupt pulse |
| irqHi | output | 1 | Upper-half interrupt pulse |

## Verification
A register write takes effect at the clock edge that samples the strobe, so the bench reads it back half a cycle later through the combinational read path. A tick moves the counter at its own edge. An interrupt caused by a matching tick is high during the cycle right after that edge. The bench therefore drives every input at the falling edge and samples interrupts and read data at the next falling edge, so each result is checked one edge after its cause. Over sweeps of small periods and tick counts, the bench derives the expected interrupt count and final counter from the quotient and remainder of the tick count by period plus one, and from the minimum of the tick count and the period for one-shot runs.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

  localparam int NUM_HALVES = 2;

  localparam int ADDR_CNT_LO = 'h10;
  localparam int ADDR_CNT_HI = 'h14;
  localparam int ADDR_PRD_LO = 'h18;
  localparam int ADDR_PRD_HI = 'h1C;
  localparam int ADDR_MODE   = 'h20;
  localparam int ADDR_GLOBAL = 'h24;

  localparam int MODE_LO_LSB = 6;
  localparam int MODE_HI_LSB = 22;

  localparam logic [1:0] LAYOUT_SPLIT = 2'd1;

  typedef enum logic [1:0] {
    EN_OFF  = 2'd0,
    EN_ONCE = 2'd1,
    EN_LOOP = 2'd2,
    EN_RSVD = 2'd3
  } enMode_e;

  typedef struct packed {
    logic [NUM_HALVES-1:0] wrCnt;
    logic [NUM_HALVES-1:0] wrPrd;
    logic [NUM_HALVES-1:0] rearm;
    logic [NUM_HALVES-1:0] run;
    logic                  countOk;
    enMode_e               modeHi;
    enMode_e               modeLo;
  } tmrCmd_t;

endpackage

// File: rtl/split_timer_ctrl.sv
module split_timer_ctrl
  import split_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                tickEn,
  input  logic [ADDR_W-1:0]                   busAddr,
  input  logic                                busWrEn,
  input  logic [HALF_W-1:0]                   busWrData,
  input  logic [NUM_HALVES-1:0][HALF_W-1:0]   cntQ,
  input  logic [NUM_HALVES-1:0][HALF_W-1:0]   prdQ,
  output tmrCmd_t                             cmd,
  output logic [HALF_W-1:0]                   busRdData
);

  logic                  hitCntLo, hitCntHi, hitPrdLo, hitPrdHi, hitMode, hitGlobal;
  enMode_e               modeLoQ, modeHiQ;
  logic [NUM_HALVES-1:0] runQ;
  logic [1:0]            layoutQ;

  assign hitCntLo  = (busAddr == ADDR_W'(ADDR_CNT_LO));
  assign hitCntHi  = (busAddr == ADDR_W'(ADDR_CNT_HI));
  assign hitPrdLo  = (busAddr == ADDR_W'(ADDR_PRD_LO));
  assign hitPrdHi  = (busAddr == ADDR_W'(ADDR_PRD_HI));
  assign hitMode   = (busAddr == ADDR_W'(ADDR_MODE));
  assign hitGlobal = (busAddr == ADDR_W'(ADDR_GLOBAL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeLoQ <= EN_OFF;
      modeHiQ <= EN_OFF;
      runQ    <= '0;
      layoutQ <= '0;
    end else if (busWrEn) begin
      if (hitMode) begin
        modeLoQ <= enMode_e'(busWrData[MODE_LO_LSB +: 2]);
        modeHiQ <= enMode_e'(busWrData[MODE_HI_LSB +: 2]);
      end
      if (hitGlobal) begin
        runQ    <= busWrData[1:0];
        layoutQ <= busWrData[3:2];
      end
    end
  end

  always_comb begin
    cmd         = '0;
    cmd.wrCnt   = {busWrEn && hitCntHi, busWrEn && hitCntLo};
    cmd.wrPrd   = {busWrEn && hitPrdHi, busWrEn && hitPrdLo};
    cmd.rearm   = {2{busWrEn && hitMode}};
    cmd.run     = runQ;
    cmd.countOk = tickEn && (layoutQ == LAYOUT_SPLIT);
    cmd.modeLo  = modeLoQ;
    cmd.modeHi  = modeHiQ;
  end

  always_comb begin
    busRdData = '0;
    if (hitCntLo)  busRdData = cntQ[0];
    if (hitCntHi)  busRdData = cntQ[1];
    if (hitPrdLo)  busRdData = prdQ[0];
    if (hitPrdHi)  busRdData = prdQ[1];
    if (hitMode) begin
      busRdData[MODE_LO_LSB +: 2] = modeLoQ;
      busRdData[MODE_HI_LSB +: 2] = modeHiQ;
    end
    if (hitGlobal) busRdData[3:0] = {layoutQ, runQ};
  end

endmodule

// File: rtl/split_timer_dp.sv
module split_timer_dp
  import split_timer_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  tmrCmd_t                           cmd,
  input  logic [HALF_W-1:0]                 wrData,
  output logic [NUM_HALVES-1:0][HALF_W-1:0] cntQ,
  output logic [NUM_HALVES-1:0][HALF_W-1:0] prdQ,
  output logic [NUM_HALVES-1:0]             irqQ
);

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    enMode_e           mode;
    logic [HALF_W-1:0] cnt, prd;
    logic              done, irq, active, atEnd;

    assign mode   = (h == 0) ? cmd.modeLo : cmd.modeHi;
    assign active = (mode == EN_ONCE) || (mode == EN_LOOP);
    assign atEnd  = (cnt == prd);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt  <= '0;
        prd  <= '1;
        done <= 1'b0;
        irq  <= 1'b0;
      end else begin
        irq <= 1'b0;
        if (cmd.wrPrd[h]) prd <= wrData;
        if (!cmd.run[h]) begin
          cnt  <= '0;
          done <= 1'b0;
        end else if (cmd.wrCnt[h]) begin
          cnt  <= wrData;
          done <= 1'b0;
        end else begin
          if (cmd.rearm[h]) done <= 1'b0;
          if (cmd.countOk && active) begin
            if (!atEnd) begin
              cnt <= cnt + 1'b1;
            end else if (mode == EN_LOOP) begin
              cnt <= '0;
              irq <= 1'b1;
            end else if (!done) begin
              irq  <= 1'b1;
              done <= 1'b1;
            end
          end
        end
      end
    end

    assign cntQ[h] = cnt;
    assign prdQ[h] = prd;
    assign irqQ[h] = irq;
  end

endmodule

// File: rtl/split_timer_core.sv
module split_timer_core
  import split_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [HALF_W-1:0] busWrData,
  output logic [HALF_W-1:0] busRdData,
  output logic              irqLo,
  output logic              irqHi
);

  tmrCmd_t                           cmd;
  logic [NUM_HALVES-1:0][HALF_W-1:0] cntQ, prdQ;
  logic [NUM_HALVES-1:0]             irqQ;

  split_timer_ctrl #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .cntQ      (cntQ),
    .prdQ      (prdQ),
    .cmd       (cmd),
    .busRdData (busRdData)
  );

  split_timer_dp #(.HALF_W(HALF_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .wrData (busWrData),
    .cntQ   (cntQ),
    .prdQ   (prdQ),
    .irqQ   (irqQ)
  );

  assign irqLo = irqQ[0];
  assign irqHi = irqQ[1];

endmodule

// File: rtl/split_timer_checker.sv
module split_timer_checker
  import split_timer_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              tickEn,
  input tmrCmd_t                           cmd,
  input logic [NUM_HALVES-1:0][HALF_W-1:0] cntQ,
  input logic [NUM_HALVES-1:0][HALF_W-1:0] prdQ,
  input logic                              irqLo,
  input logic                              irqHi
);

  logic [NUM_HALVES-1:0] irqV;
  assign irqV = {irqHi, irqLo};

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_chk
    enMode_e m;
    assign m = (h == 0) ? cmd.modeLo : cmd.modeHi;

    p_hold_in_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
      !cmd.run[h] |=> (cntQ[h] == '0) && !irqV[h]);

    p_irq_at_match_r7: assert property (@(posedge clk) disable iff (!rstN)
      irqV[h] |-> ($past(cntQ[h]) == $past(prdQ[h])));

    p_no_tick_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
      (cmd.run[h] && !cmd.wrCnt[h] && !tickEn) |=> $stable(cntQ[h]));

    p_off_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
      (cmd.run[h] && !cmd.wrCnt[h] && (m == EN_OFF || m == EN_RSVD)) |=> $stable(cntQ[h]));

    p_loop_wraps_r7: assert property (@(posedge clk) disable iff (!rstN)
      (cmd.run[h] && !cmd.wrCnt[h] && cmd.countOk && m == EN_LOOP && cntQ[h] == prdQ[h])
      |=> (cntQ[h] == '0) && irqV[h]);

    p_once_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
      (cmd.run[h] && !cmd.wrCnt[h] && m == EN_ONCE && cntQ[h] == prdQ[h]) |=> $stable(cntQ[h]));
  end

endmodule

bind split_timer_core split_timer_checker #(.HALF_W(HALF_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .tickEn (tickEn),
  .cmd    (cmd),
  .cntQ   (cntQ),
  .prdQ   (prdQ),
  .irqLo  (irqLo),
  .irqHi  (irqHi)
);

// File: tb/split_timer_core_bench.sv
module split_timer_core_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqLo, irqHi;

  int nChecks = 0;
  int nFails  = 0;
  bit summaryDone = 0;

  always #10 clk = ~clk;

  split_timer_core u_split_timer_core (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqLo(irqLo), .irqHi(irqHi)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic runTicks(int n, bit en, output int nLo, output int nHi);
    nLo = 0; nHi = 0;
    @(negedge clk);
    tickEn = en;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      nLo += int'(irqLo);
      nHi += int'(irqHi);
    end
    tickEn = 1'b0;
  endtask

  function automatic int minI(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    int nLo, nHi;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 reset state
    rd(8'h10, d); check("R2 cntLo", d, 32'h0);
    rd(8'h14, d); check("R2 cntHi", d, 32'h0);
    rd(8'h18, d); check("R2 prdLo", d, 32'hFFFF_FFFF);
    rd(8'h1C, d); check("R2 prdHi", d, 32'hFFFF_FFFF);
    rd(8'h20, d); check("R2 mode", d, 32'h0);
    rd(8'h24, d); check("R2 global", d, 32'h0);
    check("R2 irqs", {30'h0, irqHi, irqLo}, 32'h0);

    // R3 held in reset: mode/period stored, counter writes ignored
    wr(8'h20, 32'hFFFF_FFFF & 32'h0080_0080);
    wr(8'h18, 32'd3);
    wr(8'h10, 32'd5);
    rd(8'h10, d); check("R3 cnt held zero", d, 32'h0);
    rd(8'h18, d); check("R3 period accepted", d, 32'd3);
    rd(8'h20, d); check("R1 R5 mode field readback", d, 32'h0080_0080);
    runTicks(6, 1'b1, nLo, nHi);
    check("R3 no irq in reset", nLo + nHi, 0);
    rd(8'h10, d); check("R3 cnt zero after ticks", d, 32'h0);

    // R4 layout other than split freezes counters
    wr(8'h24, 32'hB);
    rd(8'h24, d); check("R1 global readback", d, 32'hB);
    runTicks(4, 1'b1, nLo, nHi);
    rd(8'h10, d); check("R4 frozen lo", d, 32'h0);
    rd(8'h14, d); check("R4 frozen hi", d, 32'h0);
    wr(8'h24, 32'h7);

    // R7 R10 continuous sweep, independent periods per half
    for (int p = 0; p < 6; p++) begin
      for (int n = 1; n <= 12; n++) begin
        wr(8'h18, p);
        wr(8'h1C, p + 2);
        wr(8'h10, 0);
        wr(8'h14, 0);
        runTicks(n, 1'b1, nLo, nHi);
        check("R7 loop irq count lo", nLo, n / (p + 1));
        check("R10 loop irq count hi", nHi, n / (p + 3));
        rd(8'h10, d); check("R7 loop cnt lo", d, n % (p + 1));
        rd(8'h14, d); check("R10 loop cnt hi", d, n % (p + 3));
      end
    end

    // R8 one-shot sweep
    wr(8'h20, 32'h0040_0040);
    for (int p = 0; p < 5; p++) begin
      for (int n = 1; n <= 9; n++) begin
        wr(8'h18, p);
        wr(8'h1C, p + 2);
        wr(8'h10, 0);
        wr(8'h14, 0);
        runTicks(n, 1'b1, nLo, nHi);
        check("R8 once irq lo", nLo, (n > p) ? 1 : 0);
        check("R8 once irq hi", nHi, (n > p + 2) ? 1 : 0);
        rd(8'h10, d); check("R8 once cnt lo", d, minI(n, p));
        rd(8'h14, d); check("R8 once cnt hi", d, minI(n, p + 2));
      end
    end
    // R8 rearm by rewriting mode register: lo sits at period 4
    runTicks(3, 1'b1, nLo, nHi);
    check("R8 no repeat irq", nLo, 0);
    wr(8'h20, 32'h0040_0040);
    runTicks(1, 1'b1, nLo, nHi);
    check("R8 rearm irq", nLo, 1);
    rd(8'h10, d); check("R8 rearm cnt holds", d, 32'd4);

    // R5 off and reserved encodings hold value
    wr(8'h20, 32'h0);
    wr(8'h10, 32'd7);
    runTicks(5, 1'b1, nLo, nHi);
    rd(8'h10, d); check("R5 off holds", d, 32'd7);
    check("R5 off no irq", nLo + nHi, 0);
    wr(8'h20, 32'h00C0_00C0);
    runTicks(5, 1'b1, nLo, nHi);
    rd(8'h10, d); check("R5 reserved holds", d, 32'd7);

    // R6 no tick enable, no count
    wr(8'h20, 32'h0080_0080);
    wr(8'h18, 32'hFFFF_FFFF);
    runTicks(6, 1'b0, nLo, nHi);
    rd(8'h10, d); check("R6 idle holds", d, 32'd7);
    runTicks(2, 1'b1, nLo, nHi);
    rd(8'h10, d); check("R6 counts with enable", d, 32'd9);

    // R9 counter write wins over simultaneous tick
    @(negedge clk);
    tickEn = 1'b1; busAddr = 8'h10; busWrData = 32'd100; busWrEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0; busWrEn = 1'b0;
    rd(8'h10, d); check("R9 write priority", d, 32'd100);
    runTicks(1, 1'b1, nLo, nHi);
    rd(8'h10, d); check("R9 counts from loaded", d, 32'd101);

    // R10 releasing only lo keeps hi held
    wr(8'h14, 32'd3);
    wr(8'h24, 32'h5);
    rd(8'h14, d); check("R10 hi held", d, 32'h0);
    runTicks(2, 1'b1, nLo, nHi);
    rd(8'h10, d); check("R10 lo still runs", d, 32'd103);

    // R1 unmapped addresses
    rd(8'h28, d); check("R1 addr 0x28 zero", d, 32'h0);
    rd(8'h00, d); check("R1 addr 0x00 zero", d, 32'h0);

    finishRun();
  end

endmodule